// File: doc/BRIEF.md
# Line Event Timestamping Engine

The engine watches a bank of asynchronous input lines. It brings each line into the clock domain, detects every change of level and, for each line that software has enabled, stores a record in a shared 256-entry FIFO. A record holds the 64-bit value of the chip's system time input in the cycle the change was seen, the index of the line, and the line's new level. Lines are grouped into 32-bit enable slices. The `SLICES` parameter sets how many slices there are; the intended builds use 3 slices (96 lines) or 11 slices (352 lines).

Software reads records through a small word-addressed register port. Reading the record word removes one entry from the FIFO and latches its timestamp, which software then reads as two 32-bit halves. An interrupt output stays high while the number of stored records is at or above a threshold that software programs. Events that arrive while the FIFO is full are lost, and a sticky flag records the loss.

Top module: `lts_engine`

## Requirements
- R1: Each line passes through two synchronising flops. A change on a line is detected one cycle after it leaves the second flop. The captured timestamp is the `sys_time` value in that detection cycle. When `sys_time` is held stable around a change, the record's timestamp equals that value.
- R2: Reading word address 2 pops one record and returns bit 31 = 1 (valid), bit 16 = the new level, and bits 15:0 = the line index. The pop latches the record's timestamp: address 3 then reads timestamp bits 31:0 and address 4 reads bits 63:32.
- R3: A line whose enable bit is clear produces no record when it changes.
- R4: When several enabled lines change in the same cycle, one record per cycle is written in ascending order of line index. All of these records carry the same timestamp.
- R5: Enable slice s sits at word address 8+s. Bit b of that slice enables line 32*s+b. The slice reads back as written.
- R6: `irq` is high exactly while the FIFO occupancy is greater than or equal to the threshold.
- R7: The threshold register is at address 0 and resets to 1. A written value below 1 is stored as 1, and a value above 256 is stored as 256.
- R8: The FIFO holds 256 records. An event that arrives while the FIFO is full is dropped and sets the overflow flag. The status word at address 1 reads bit 0 = overflow, bit 1 = irq, and bits 24:16 = occupancy.
- R9: The overflow flag stays set until software writes the status word with bit 0 = 1.
- R10: Popping an empty FIFO returns 0 and changes no flag or count.
- R11: After reset, the occupancy is 0, the overflow flag is 0, `irq` is 0, all enables are 0 and the read data is 0.
- R12: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | SLICES*32 | Asynchronous lines under watch |
| sys_time | input | 64 | Free-running system time value |
| reg_addr | input | 6 | Word address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of address 2 pops a record) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Occupancy-threshold interrupt |

## Verification
The assertions assume three things about the inputs: `reg_wr` and `reg_rd` are never high together, each line holds its level for at least two clocks so that every change reaches the detector, and a line does not change again while its earlier event is still waiting to be written. The bench drives every input at the falling clock edge and keeps accesses one at a time. It spaces the repeated toggles of a single line four cycles apart and holds `sys_time` steady across each change, so every expected timestamp is exact.

// File: rtl/lts_pkg.sv
package lts_pkg;
    localparam int SLICE_W    = 32;
    localparam int TS_W       = 64;
    localparam int IDX_W      = 16;
    localparam int FIFO_DEPTH = 256;
    localparam int THR_MIN    = 1;
    localparam int THR_MAX    = 256;
    localparam int THR_W      = $clog2(THR_MAX + 1);
    localparam int ADDR_W     = 6;

    localparam logic [ADDR_W-1:0] A_THR     = 6'd0;
    localparam logic [ADDR_W-1:0] A_STAT    = 6'd1;
    localparam logic [ADDR_W-1:0] A_REC     = 6'd2;
    localparam logic [ADDR_W-1:0] A_TSLO    = 6'd3;
    localparam logic [ADDR_W-1:0] A_TSHI    = 6'd4;
    localparam logic [ADDR_W-1:0] A_EN_BASE = 6'd8;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic             lvl;
        logic [IDX_W-1:0] line;
    } rec_t;

    function automatic logic [THR_W-1:0] clamp_thr(input logic [31:0] v);
        if (v < 32'(THR_MIN))
            return THR_W'(THR_MIN);
        else if (v > 32'(THR_MAX))
            return THR_W'(THR_MAX);
        else
            return v[THR_W-1:0];
    endfunction
endpackage

// File: rtl/lts_capture.sv
module lts_capture
    import lts_pkg::*;
#(
    parameter int LINES = 96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] en,
    input  logic [LINES-1:0] clr,
    input  logic [TS_W-1:0]  sys_time,
    output logic [LINES-1:0] pend,
    output logic [LINES-1:0] lvl,
    output logic [TS_W-1:0]  ts [LINES]
);
    logic [LINES-1:0] s1, s2, s3;
    logic [LINES-1:0] take;

    // a waiting line ignores a further change unless it is being serviced now
    assign take = (s2 ^ s3) & en & (~pend | clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= '0;
            s2   <= '0;
            s3   <= '0;
            pend <= '0;
            lvl  <= '0;
        end else begin
            s1   <= line_in;
            s2   <= s1;
            s3   <= s2;
            pend <= take | (pend & ~clr);
            lvl  <= (take & s2) | (~take & lvl);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (take[i]) ts[i] <= sys_time;
        end
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_chk
            // R3: a pending event only appears on an enabled line
            a_r3_enable_gate: assert property (@(posedge clk) disable iff (rst)
                $rose(pend[g]) |-> $past(en[g]));
        end
    endgenerate
endmodule

// File: rtl/lts_pick.sv
module lts_pick
    import lts_pkg::*;
#(
    parameter int LINES = 96
) (
    input  logic [LINES-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [LINES-1:0] onehot
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        onehot = any ? (LINES'(1) << idx) : '0;
    end
endmodule

// File: rtl/lts_fifo.sv
module lts_fifo
    import lts_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  rec_t                       din,
    output rec_t                       dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rec_t             mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8: occupancy never exceeds the depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    // R8: a push while full and without a pop leaves the FIFO full
    a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/lts_engine.sv
module lts_engine
    import lts_pkg::*;
#(
    parameter int SLICES = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SLICES*SLICE_W-1:0] line_in,
    input  logic [TS_W-1:0]           sys_time,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      irq
);
    localparam int LINES = SLICES * SLICE_W;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [SLICE_W-1:0] en_q [SLICES];
    logic [LINES-1:0]   en_flat;
    logic [LINES-1:0]   pend, lvl, clr;
    logic [TS_W-1:0]    ts_arr [LINES];
    logic               any;
    logic [IDX_W-1:0]   idx;
    rec_t               rec_in, rec_out;
    logic [CNT_W-1:0]   count;
    logic               full, empty, push, pop;
    logic [THR_W-1:0]   thr_q;
    logic               ovf_q;
    logic [TS_W-1:0]    ts_lat;
    logic [31:0]        rd_val;
    logic               rd_rec;

    generate
        for (genvar s = 0; s < SLICES; s++) begin : g_en
            assign en_flat[s*SLICE_W +: SLICE_W] = en_q[s];
        end
    endgenerate

    lts_capture #(.LINES(LINES)) u_cap (
        .clk(clk), .rst(rst), .line_in(line_in), .en(en_flat), .clr(clr),
        .sys_time(sys_time), .pend(pend), .lvl(lvl), .ts(ts_arr)
    );

    lts_pick #(.LINES(LINES)) u_pick (
        .pend(pend), .any(any), .idx(idx), .onehot(clr)
    );

    assign rec_in.ts   = ts_arr[idx];
    assign rec_in.lvl  = lvl[idx];
    assign rec_in.line = idx;
    assign push        = any && !full;
    assign rd_rec      = reg_rd && (reg_addr == A_REC);
    assign pop         = rd_rec && !empty;

    lts_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .din(rec_in),
        .dout(rec_out), .count(count), .full(full), .empty(empty)
    );

    assign irq = (count >= thr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= THR_W'(THR_MIN);
            ovf_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_THR) thr_q <= clamp_thr(reg_wdata);
            if (any && full)
                ovf_q <= 1'b1;
            else if (reg_wr && reg_addr == A_STAT && reg_wdata[0])
                ovf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < SLICES; s++) begin
            if (rst)
                en_q[s] <= '0;
            else if (reg_wr && reg_addr == A_EN_BASE + ADDR_W'(s))
                en_q[s] <= reg_wdata;
        end
    end

    always_comb begin
        rd_val = '0;
        case (reg_addr)
            A_THR:  rd_val = 32'(thr_q);
            A_STAT: rd_val = {7'b0, count, 14'b0, irq, ovf_q};
            A_REC:  rd_val = empty ? '0 : {1'b1, 14'b0, rec_out.lvl, rec_out.line};
            A_TSLO: rd_val = ts_lat[31:0];
            A_TSHI: rd_val = ts_lat[63:32];
            default: begin
                for (int s = 0; s < SLICES; s++) begin
                    if (reg_addr == A_EN_BASE + ADDR_W'(s)) rd_val = en_q[s];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            ts_lat    <= '0;
        end else begin
            if (reg_rd) reg_rdata <= rd_val;
            if (rd_rec) ts_lat <= empty ? '0 : rec_out.ts;
        end
    end

    // R7: stored threshold always within 1..256
    a_r7_thr_range: assert property (@(posedge clk) disable iff (rst)
        (thr_q >= THR_W'(THR_MIN)) && (thr_q <= THR_W'(THR_MAX)));
    // R9: overflow stays set unless cleared by a write of 1
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(reg_wr && reg_addr == A_STAT && reg_wdata[0])) |=> ovf_q);
    // R10: a pop of an empty FIFO returns zero
    a_r10_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_rec && empty) |=> (reg_rdata == 32'd0));
    // R10: a pop of an empty FIFO leaves the count at zero
    a_r10_empty_pop_count: assert property (@(posedge clk) disable iff (rst)
        (rd_rec && empty && !any) |=> (count == '0));
endmodule

// File: tb/lts_engine_tb.sv
module lts_engine_tb;
    localparam int SLICES = 3;
    localparam int LINES  = SLICES * 32;

    logic             clk = 1'b0;
    logic             rst;
    logic [LINES-1:0] lines;
    logic [63:0]      sys_time;
    logic [5:0]       reg_addr;
    logic             reg_wr, reg_rd;
    logic [31:0]      reg_wdata;
    logic [31:0]      reg_rdata;
    logic             irq;

    typedef struct {
        int          line;
        bit          lvl;
        logic [63:0] ts;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;

    always #4 clk = ~clk;

    lts_engine #(.SLICES(SLICES)) u_dut (
        .clk(clk), .rst(rst), .line_in(lines), .sys_time(sys_time),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        v        = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard
    task automatic expect_rec(input int line, input bit lvl, input logic [63:0] ts);
        exp_t e;
        e.line = line;
        e.lvl  = lvl;
        e.ts   = ts;
        q.push_back(e);
    endtask

    // monitor side: pop records through the register port and compare
    task automatic drain(input int n);
        logic [31:0] v, lo, hi;
        exp_t e;
        for (int k = 0; k < n; k++) begin
            e = q.pop_front();
            reg_read(6'd2, v);
            check("R2 R4 record word", 64'(v), 64'(32'h8000_0000 | (32'(e.lvl) << 16) | 32'(e.line)));
            reg_read(6'd3, lo);
            reg_read(6'd4, hi);
            check("R1 R2 timestamp", {hi, lo}, e.ts);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst       = 1'b1;
        lines     = '0;
        sys_time  = '0;
        reg_addr  = '0;
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_wdata = '0;
        wait_cyc(4);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check("R11 rdata after reset", 64'(reg_rdata), 64'd0);
        check("R11 irq after reset", 64'(irq), 64'd0);
        reg_read(6'd1, v);
        check("R11 status after reset", 64'(v), 64'd0);
        reg_read(6'd0, v);
        check("R7 threshold default", 64'(v), 64'd1);
        reg_read(6'd8, v);
        check("R11 enable slice 0 after reset", 64'(v), 64'd0);
        // R10 empty pop
        reg_read(6'd2, v);
        check("R10 empty pop value", 64'(v), 64'd0);
        reg_read(6'd1, v);
        check("R10 status after empty pop", 64'(v), 64'd0);
        // R12 holding read data
        wait_cyc(3);
        check("R12 rdata holds", 64'(reg_rdata), 64'(v));

        // R5 enables: lines 2,5 (slice 0), 40 (slice 1), 70 (slice 2); line 3 stays off
        reg_write(6'd8, 32'h0000_0024);
        reg_write(6'd9, 32'h0000_0100);
        reg_write(6'd10, 32'h0000_0040);
        reg_read(6'd9, v);
        check("R5 slice 1 readback", 64'(v), 64'h100);
        reg_read(6'd10, v);
        check("R5 slice 2 readback", 64'(v), 64'h40);

        // R1 R2 single event
        @(negedge clk);
        sys_time  = 64'h1111_2222_3333_0001;
        lines[5]  = 1'b1;
        expect_rec(5, 1'b1, 64'h1111_2222_3333_0001);
        wait_cyc(8);
        reg_read(6'd1, v);
        check("R8 occupancy after one event", 64'(v[24:16]), 64'd1);
        drain(1);

        // R3 R4 simultaneous changes incl. disabled line 3
        @(negedge clk);
        sys_time  = 64'hABCD_0000_0000_0777;
        lines[70] = 1'b1;
        lines[40] = 1'b1;
        lines[5]  = 1'b0;
        lines[2]  = 1'b1;
        lines[3]  = 1'b1;
        expect_rec(2, 1'b1, 64'hABCD_0000_0000_0777);
        expect_rec(5, 1'b0, 64'hABCD_0000_0000_0777);
        expect_rec(40, 1'b1, 64'hABCD_0000_0000_0777);
        expect_rec(70, 1'b1, 64'hABCD_0000_0000_0777);
        wait_cyc(10);
        reg_read(6'd1, v);
        check("R3 disabled line adds no record", 64'(v[24:16]), 64'd4);
        drain(4);
        @(negedge clk);
        lines[3] = 1'b0;
        wait_cyc(8);
        reg_read(6'd1, v);
        check("R3 disabled line fall ignored", 64'(v[24:16]), 64'd0);

        // R7 clamp
        reg_write(6'd0, 32'd0);
        reg_read(6'd0, v);
        check("R7 clamp low", 64'(v), 64'd1);
        reg_write(6'd0, 32'd1000);
        reg_read(6'd0, v);
        check("R7 clamp high", 64'(v), 64'd256);
        reg_write(6'd0, 32'd3);
        reg_read(6'd0, v);
        check("R7 in-range value", 64'(v), 64'd3);

        // R6 threshold interrupt
        @(negedge clk);
        sys_time = 64'h50;
        lines[2] = 1'b0;
        expect_rec(2, 1'b0, 64'h50);
        wait_cyc(8);
        check("R6 irq below threshold (1)", 64'(irq), 64'd0);
        sys_time  = 64'h60;
        lines[40] = 1'b0;
        expect_rec(40, 1'b0, 64'h60);
        wait_cyc(8);
        check("R6 irq below threshold (2)", 64'(irq), 64'd0);
        sys_time  = 64'h70;
        lines[70] = 1'b0;
        expect_rec(70, 1'b0, 64'h70);
        wait_cyc(8);
        check("R6 irq at threshold", 64'(irq), 64'd1);
        reg_read(6'd1, v);
        check("R8 status irq bit", 64'(v[1]), 64'd1);
        drain(1);
        check("R6 irq drops after pop", 64'(irq), 64'd0);
        drain(2);

        // R8 overflow: 258 events into a 256-deep FIFO
        reg_write(6'd0, 32'd256);
        for (int k = 0; k < 258; k++) begin
            @(negedge clk);
            sys_time = 64'h1000 + 64'(k);
            lines[2] = ~lines[2];
            if (k < 256) expect_rec(2, ~k[0], 64'h1000 + 64'(k));
            wait_cyc(3);
        end
        wait_cyc(10);
        reg_read(6'd1, v);
        check("R8 occupancy at full", 64'(v[24:16]), 64'd256);
        check("R8 overflow flag set", 64'(v[0]), 64'd1);
        check("R6 irq at 256", 64'(irq), 64'd1);
        drain(256);
        reg_read(6'd2, v);
        check("R10 empty pop after drain", 64'(v), 64'd0);
        reg_read(6'd1, v);
        check("R9 overflow still set", 64'(v), 64'd1);
        reg_write(6'd1, 32'd0);
        reg_read(6'd1, v);
        check("R9 write 0 keeps overflow", 64'(v[0]), 64'd1);
        reg_write(6'd1, 32'd1);
        reg_read(6'd1, v);
        check("R9 overflow cleared", 64'(v), 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule